// File: doc/BRIEF.md
# Single-Pin External Interrupt Controller

This block accepts one asynchronous interrupt pin. It converts activity on that pin into a sticky pending flag and raises an active-high level request toward a parent interrupt controller. Software picks one of four trigger modes: low level, high level, falling edge or rising edge. Software clears the flag by writing a one to the pending register, and gates the request with an enable bit.

The pin is brought into the clock domain through a two-stage synchronizer. Edge modes compare the synchronized value with its value one clock earlier. Level modes test the synchronized value directly. The flag is recorded even while the request is disabled, so software can poll it.

The three registers sit at offsets set by parameters. One build can therefore serve a compact map or a sparse one. Access is through a plain 32-bit read/write strobe interface with a combinational read path.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers read as zero and `irq_o` is low.
- R2: Control bits [1:0] choose the trigger: 0 is low level, 1 is falling edge, 2 is high level, 3 is rising edge. An edge mode does not react to the opposite edge or to a steady level.
- R3: The pin passes through two synchronizing flops. A pin change made between rising edges shows in the pending flag after the third rising clock edge, and not after the second.
- R4: Bit 0 of the pending register reports the flag. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R5: In a level mode, an acknowledge written while the pin is still active clears the flag for one cycle. The flag sets again on the next clock.
- R6: In an edge mode, if a detected edge and an acknowledge write fall in the same cycle, the flag stays set.
- R7: The flag latches whatever the enable bit (enable register bit 0) holds. `irq_o` is high exactly when the flag and the enable bit are both set. A write to the enable register changes `irq_o` from the next cycle on.
- R8: Control bits [7:2] are stored and read back but do not affect detection. Control bits [31:8] and enable bits [31:1] read as zero.
- R9: The control, pending and enable offsets are parameters. The default map is 0x00, 0x04, 0x08, and an alternative build uses 0x0C, 0x10, 0x40.
- R10: A read at an offset that maps to no register returns zero. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | External interrupt pin, asynchronous, idles high |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, read data returned in the same cycle |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, zero when no read or no register is addressed |
| irq_o | output | 1 | Active-high level request to the parent controller |

## Verification
Two events can land in the same cycle: a software acknowledge and a fresh trigger from the pin. The bench times a rising edge on the pin so that its detection meets the clock edge that carries an acknowledge write. It then reads the flag and expects it to still be set. In high-level mode the bench acknowledges while the pin is held active. It expects the flag to read clear right after the write and set again one clock later, so an acknowledge that is dropped, or that wins for longer than one cycle, is reported.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Trigger selector held in control bits [1:0]
  typedef enum logic [1:0] {
    TRIG_LVL_LO   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI   = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int unsigned TRIG_W = 2;

endpackage

// File: rtl/extirq_sync.sv
// Flop chain used both for the pin synchronizer and the reset release.
module extirq_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{IDLE}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/extirq_detect.sv
// Edge and level decode of the synchronized pin.
module extirq_detect
  import extirq_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_s_i,
  input  trig_e trig_i,
  output logic  edge_evt_o,
  output logic  lvl_act_o
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= IDLE;
    end else begin
      prev_q <= pin_s_i;
    end
  end

  always_comb begin
    rise       = pin_s_i & ~prev_q;
    fall       = ~pin_s_i & prev_q;
    edge_evt_o = 1'b0;
    lvl_act_o  = 1'b0;
    case (trig_i)
      TRIG_EDGE_RISE: edge_evt_o = rise;
      TRIG_EDGE_FALL: edge_evt_o = fall;
      TRIG_LVL_HI:    lvl_act_o  = pin_s_i;
      default:        lvl_act_o  = ~pin_s_i;
    endcase
  end

endmodule

// File: rtl/extirq_pend.sv
// Sticky pending flag. An edge beats an acknowledge in the same cycle;
// an acknowledge beats a level for one cycle.
module extirq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_evt_i,
  input  logic lvl_act_i,
  input  logic ack_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = edge_evt_i | ((lvl_act_i | pend_q) & ~ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/extirq_regs.sv
// Register decode: control, pending (read / write-one-to-ack), enable.
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned OFF_CTRL = 'h00,
  parameter int unsigned OFF_PEND = 'h04,
  parameter int unsigned OFF_EN   = 'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output trig_e             trig_o,
  output logic              en_o,
  output logic              ack_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);

  logic              hit_ctrl, hit_pend, hit_en;
  logic              ctrl_we, en_we;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              en_q, en_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_W];

  always_comb begin
    hit_ctrl = (addr_i == A_CTRL);
    hit_pend = (addr_i == A_PEND);
    hit_en   = (addr_i == A_EN);
    ctrl_we  = wr_i & hit_ctrl;
    en_we    = wr_i & hit_en;
    ctrl_d   = wdata_i[CTRL_W-1:0];
    en_d     = wdata_i[0];
    ack_o    = wr_i & hit_pend & wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_ctrl) begin
        rdata_o[CTRL_W-1:0] = ctrl_q;
      end else if (hit_pend) begin
        rdata_o[0] = pend_i;
      end else if (hit_en) begin
        rdata_o[0] = en_q;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign trig_o = trig_e'(ctrl_q[TRIG_W-1:0]);
  assign en_o   = en_q;

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        PIN_IDLE    = 1'b1,
  parameter int unsigned OFF_CTRL    = 'h00,
  parameter int unsigned OFF_PEND    = 'h04,
  parameter int unsigned OFF_EN      = 'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic              rst_s_n;
  logic              pin_s;
  trig_e             trig;
  logic              edge_evt;
  logic              lvl_act;
  logic              ack;
  logic              pend_q;
  logic              en_q;
  logic [CTRL_W-1:0] ctrl_q;

  // asynchronous assertion, synchronous release
  extirq_sync #(.STAGES(2), .IDLE(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_s_n)
  );

  extirq_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_s_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  extirq_detect #(.IDLE(PIN_IDLE)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_s_n),
    .pin_s_i   (pin_s),
    .trig_i    (trig),
    .edge_evt_o(edge_evt),
    .lvl_act_o (lvl_act)
  );

  extirq_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_s_n),
    .edge_evt_i(edge_evt),
    .lvl_act_i (lvl_act),
    .ack_i     (ack),
    .pend_o    (pend_q)
  );

  extirq_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTRL_W  (CTRL_W),
    .OFF_CTRL(OFF_CTRL),
    .OFF_PEND(OFF_PEND),
    .OFF_EN  (OFF_EN)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .wr_i   (bus_wr_i),
    .rd_i   (bus_rd_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .pend_i (pend_q),
    .rdata_o(bus_rdata_o),
    .ctrl_o (ctrl_q),
    .trig_o (trig),
    .en_o   (en_q),
    .ack_o  (ack)
  );

  assign irq_o = pend_q & en_q;

endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
  import extirq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned OFF_CTRL = 'h00,
  parameter int unsigned OFF_PEND = 'h04,
  parameter int unsigned OFF_EN   = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pin_s,
  input trig_e             trig,
  input logic              edge_evt,
  input logic              lvl_act,
  input logic              pend,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl
);

  logic ack_wr, en_off_wr, ctrl_wr;

  assign ack_wr    = bus_wr && (bus_addr == ADDR_W'(OFF_PEND)) && bus_wdata[0];
  assign en_off_wr = bus_wr && (bus_addr == ADDR_W'(OFF_EN)) && !bus_wdata[0];
  assign ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack_wr |=> pend);                                   // R4
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && !edge_evt && !lvl_act |=> !pend);                  // R4
  AST_LVL_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && lvl_act |=> !pend);                                // R5
  AST_LVL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_act && !ack_wr |=> pend);                                // R5
  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && ack_wr |=> pend);                                // R6
  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE_RISE) && $rose(pin_s) |=> pend);          // R2
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_off_wr |=> !irq);                                         // R7
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl));                                 // R10

endmodule

bind extirq_ctrl extirq_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CTRL_W  (CTRL_W),
  .OFF_CTRL(OFF_CTRL),
  .OFF_PEND(OFF_PEND),
  .OFF_EN  (OFF_EN)
) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_s_n),
  .bus_wr   (bus_wr_i),
  .bus_addr (bus_addr_i),
  .bus_wdata(bus_wdata_i),
  .pin_s    (pin_s),
  .trig     (trig),
  .edge_evt (edge_evt),
  .lvl_act  (lvl_act),
  .pend     (pend_q),
  .irq      (irq_o),
  .ctrl     (ctrl_q)
);

// File: tb/tb_extirq_ctrl.sv
module tb_extirq_ctrl;

  localparam logic [7:0] A_CTRL = 8'h00, A_PEND = 8'h04, A_EN = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin;
  logic        wr, rd;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, rdata_alt;
  logic        irq, irq_alt;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  extirq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  extirq_ctrl #(.OFF_CTRL('h0C), .OFF_PEND('h10), .OFF_EN('h40)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_alt), .irq_o(irq_alt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic read_alt(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata_alt;
    rd = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk);
    pin = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_CTRL, d); chk("R1 ctrl after reset", d, 0);
    bus_read(A_PEND, d); chk("R1 pending after reset", d, 0);
    bus_read(A_EN, d);   chk("R1 enable after reset", d, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    bus_write(A_CTRL, 3); bus_write(A_EN, 1); bus_write(A_PEND, 1);
    pin_set(1'b0); settle();
    bus_read(A_PEND, d); chk("R2 rising mode ignores falling edge", d, 0);
    pin_set(1'b1);
    repeat (2) @(posedge clk); #1;
    bus_read(A_PEND, d); chk("R3 not pending after two edges", d, 0);
    @(posedge clk); #1;
    bus_read(A_PEND, d); chk("R3 pending after third edge", d, 1);
    chk("R7 irq with pending and enable", {31'b0, irq}, 1);
    bus_write(A_PEND, 0);
    bus_read(A_PEND, d); chk("R4 write 0 keeps pending", d, 1);
    bus_write(A_PEND, 1);
    bus_read(A_PEND, d); chk("R4 ack clears pending", d, 0);
    settle();
    bus_read(A_PEND, d); chk("R2 steady high sets nothing in rising mode", d, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    bus_write(A_CTRL, 1); bus_write(A_PEND, 1);
    pin_set(1'b0); settle();
    bus_read(A_PEND, d); chk("R2 falling edge sets pending", d, 1);
    bus_write(A_PEND, 1);
    pin_set(1'b1); settle();
    bus_read(A_PEND, d); chk("R2 falling mode ignores rising edge", d, 0);
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    bus_write(A_CTRL, 2); settle();
    bus_read(A_PEND, d); chk("R2 high level sets pending", d, 1);
    bus_write(A_PEND, 1);
    bus_read(A_PEND, d); chk("R5 ack gap while level active", d, 0);
    @(posedge clk); #1;
    bus_read(A_PEND, d); chk("R5 level sets again next clock", d, 1);
    pin_set(1'b0); settle();
    bus_write(A_PEND, 1); settle();
    bus_read(A_PEND, d); chk("R5 stays clear once level inactive", d, 0);
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    bus_write(A_CTRL, 0); settle();
    bus_read(A_PEND, d); chk("R2 low level sets pending", d, 1);
    pin_set(1'b1); settle();
    bus_write(A_PEND, 1); settle();
    bus_read(A_PEND, d); chk("R2 low level mode quiet with pin high", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_write(A_CTRL, 3); bus_write(A_EN, 0); bus_write(A_PEND, 1);
    pin_set(1'b0); settle();
    pin_set(1'b1); settle();
    bus_read(A_PEND, d); chk("R7 pending latches while disabled", d, 1);
    chk("R7 irq low while disabled", {31'b0, irq}, 0);
    bus_write(A_EN, 1);
    chk("R7 irq rises after enable write", {31'b0, irq}, 1);
    bus_write(A_EN, 0);
    chk("R7 irq falls after disable write", {31'b0, irq}, 0);
    bus_write(A_PEND, 1);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    bus_write(A_CTRL, 3); bus_write(A_EN, 1);
    pin_set(1'b0); settle();
    pin_set(1'b1); settle();
    pin_set(1'b0); settle();
    bus_read(A_PEND, d); chk("R6 pending before collision", d, 1);
    @(negedge clk); pin = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); wr = 1'b1; addr = A_PEND; wdata = 1;
    @(posedge clk);
    #1 wr = 1'b0;
    bus_read(A_PEND, d); chk("R6 edge in ack cycle keeps pending", d, 1);
    chk("R6 irq stays high", {31'b0, irq}, 1);
    bus_write(A_PEND, 1);
    bus_read(A_PEND, d); chk("R6 later ack clears", d, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, d); chk("R8 enable upper bits read zero", d, 1);
    bus_write(A_EN, 0);
    bus_write(A_CTRL, 32'hFFFF_FFA7);
    bus_read(A_CTRL, d); chk("R8 ctrl keeps bits 7:0 only", d, 32'hA7);
    bus_write(A_CTRL, 32'h0000_00FC);
    bus_read(A_CTRL, d); chk("R8 spare bits read back", d, 32'hFC);
    settle();
    bus_read(A_PEND, d); chk("R8 spare bits leave low level mode quiet", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(A_CTRL, 32'h5A); bus_write(A_EN, 1);
    bus_read(8'h0C, d); chk("R10 unmapped 0x0C reads zero", d, 0);
    bus_read(8'h40, d); chk("R10 unmapped 0x40 reads zero", d, 0);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'h0);
    bus_read(A_CTRL, d); chk("R10 ctrl untouched by unmapped writes", d, 32'h5A);
    bus_read(A_EN, d);   chk("R10 enable untouched by unmapped writes", d, 1);
    read_alt(8'h0C, d);  chk("R9 alternate map ctrl at 0x0C", d, 32'hFF);
    read_alt(8'h40, d);  chk("R9 alternate map enable at 0x40", d, 1);
    read_alt(8'h08, d);  chk("R9 0x08 unmapped in alternate map", d, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    t_rising();
    t_falling();
    t_level_high();
    t_level_low();
    t_enable();
    t_collision();
    t_ctrl_bits();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule